// File: doc/BRIEF.md
# Opcode-Decoded Accumulator ALU

This block is the arithmetic core of a small accumulator machine. It holds an 8-bit accumulator and three status flags (zero, carry, sign). On each clock edge it applies at most one action: a plain load of the operand, an arithmetic or logical operation chosen by the instruction code, or a step of plus or minus one. The instruction code selects the operation through fixed bit fields, so the sequencer only strobes `aluLoad` and does not need a separate function code.

The top two opcode bits name the instruction group. Only group `00` reaches the ALU. Within that group, bit 5 chooses between arithmetic and logical operations, and bits 4:3 choose the sub-function. A combinational bus value shows the result that the current opcode would produce. An address adder or a compare step can use that value without writing the accumulator.

Top module: `opAluAcc`

## Requirements
- R1: While `rstN` is low, and after its release, the accumulator reads 00h and all three flags read 0.
- R2: When `accLoad` is asserted, the accumulator takes `operand` at the clock edge and the zero, carry and sign flags keep their values.
- R3: When `aluLoad` is asserted with opcode bits 7:6 not equal to 00, neither the accumulator nor any flag changes, even if `incStrobe` or `decStrobe` is also high.
- R4: With opcode bits 7:6 = 00 and bit 5 = 0, bits 4:3 select the operation: 00 = acc+operand, 01 = acc+operand+carry, 10 = acc-operand, 11 = acc-operand-carry. Carry takes the carry-out of an add, and is set on a borrow after a subtract.
- R5: With opcode bits 7:6 = 00 and bit 5 = 1, bits 4:3 select the operation: 00 = bitwise NOT of acc, 01 = AND, 10 = OR, 11 = XOR with the operand. Carry is cleared.
- R6: On every ALU, increment or decrement update, zero is set when the 8-bit result is 00h, and sign copies result bit 7.
- R7: `incStrobe` adds one to the accumulator. Carry is set when FFh wraps to 00h.
- R8: `decStrobe` subtracts one from the accumulator. Carry is set when 00h wraps to FFh.
- R9: When several strobes are high together, only one action takes place. The order of precedence is `accLoad`, then `aluLoad`, then `incStrobe`, then `decStrobe`.
- R10: `busOut` shows, without a clock, the R4/R5 result of the current opcode, operand, accumulator and carry when bits 7:6 = 00. For any other group it shows the accumulator.
- R11: With no strobe asserted, the accumulator and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| opcode | input | 8 | Instruction code; bits 7:6 group, bit 5 kind, bits 4:3 sub-function |
| operand | input | 8 | Second operand from the designated register or the bus |
| accLoad | input | 1 | Load operand into the accumulator |
| aluLoad | input | 1 | Run the opcode-selected operation into the accumulator |
| incStrobe | input | 1 | Accumulator plus one |
| decStrobe | input | 1 | Accumulator minus one |
| accOut | output | 8 | Accumulator value |
| busOut | output | 8 | Combinational result preview for the bus |
| zeroFlag | output | 1 | Result was 00h |
| carryFlag | output | 1 | Carry out, or borrow after a subtract |
| signFlag | output | 1 | Result bit 7 |

## Verification
The add pattern 3Ch+C4h gives exactly 100h. This separates the carry-out from the zero test in one step. A following add-with-carry shows that the stored carry is fed back in. The subtract operands are chosen to borrow and then not to borrow, so subtract-with-borrow is told apart from plain subtract.

The logical operations run right after an add that sets carry, so the clearing of carry is visible. The XOR operand equals the accumulator, which drives the result to zero.

The increment and decrement steps start at FFh and 00h to reach both wrap edges. Opcodes from the three other groups are applied together with a step strobe, which shows that those groups leave the state alone. Mixed strobe combinations then show the order of precedence.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 8;

  // encoding equals {kind bit, sub-function} of the opcode
  typedef enum logic [2:0] {
    FN_ADD = 3'b000,
    FN_ADC = 3'b001,
    FN_SUB = 3'b010,
    FN_SBB = 3'b011,
    FN_NOT = 3'b100,
    FN_AND = 3'b101,
    FN_OR  = 3'b110,
    FN_XOR = 3'b111
  } aluFn_e;

  typedef struct packed {
    logic   doLoad;
    logic   doAlu;
    logic   doInc;
    logic   doDec;
    aluFn_e fn;
  } ctrlStrobes_t;
endpackage

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int W = DATA_W
) (
  input  aluFn_e       fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W:0] wide;
  logic [W:0] aExt;
  logic [W:0] bExt;
  logic [W:0] cExt;

  assign aExt = {1'b0, a};
  assign bExt = {1'b0, b};
  assign cExt = {{W{1'b0}}, cin};

  always_comb begin
    unique case (fn)
      FN_ADD:  wide = aExt + bExt;
      FN_ADC:  wide = aExt + bExt + cExt;
      FN_SUB:  wide = aExt - bExt;
      FN_SBB:  wide = aExt - bExt - cExt;
      FN_NOT:  wide = {1'b0, ~a};
      FN_AND:  wide = {1'b0, a & b};
      FN_OR:   wide = {1'b0, a | b};
      FN_XOR:  wide = {1'b0, a ^ b};
      default: wide = '0;
    endcase
  end

  assign res  = wide[W-1:0];
  assign cout = wide[W];
endmodule

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [OPW-1:0] opcode,
  input  logic           accLoad,
  input  logic           aluLoad,
  input  logic           incStrobe,
  input  logic           decStrobe,
  output ctrlStrobes_t   strb,
  output logic           groupAlu
);
  localparam int GRP_HI  = OPW - 1;
  localparam int GRP_LO  = OPW - 2;
  localparam int KIND_B  = OPW - 3;
  localparam int SUB_HI  = OPW - 4;
  localparam int SUB_LO  = OPW - 5;

  logic [2:0] fnBits;

  assign groupAlu = (opcode[GRP_HI:GRP_LO] == 2'b00);
  assign fnBits   = {opcode[KIND_B], opcode[SUB_HI:SUB_LO]};

  always_comb begin
    strb.fn     = aluFn_e'(fnBits);
    strb.doLoad = accLoad;
    strb.doAlu  = !accLoad && aluLoad && groupAlu;
    strb.doInc  = !accLoad && !aluLoad && incStrobe;
    strb.doDec  = !accLoad && !aluLoad && !incStrobe && decStrobe;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doLoad, strb.doAlu, strb.doInc, strb.doDec})); // R9

  AST_FOREIGN_GROUP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (aluLoad && !accLoad && !groupAlu) |->
      ({strb.doLoad, strb.doAlu, strb.doInc, strb.doDec} == 4'b0000)); // R3
endmodule

// File: rtl/accDatapath.sv
module accDatapath
  import aluPkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic         groupAlu,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic [W-1:0] busOut,
  output logic         zeroFlag,
  output logic         carryFlag,
  output logic         signFlag
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] opRes;
  logic         opCout;
  logic [W-1:0] stepRes;
  logic         stepCout;
  aluFn_e       stepFn;

  assign stepFn = strb.doDec ? FN_SUB : FN_ADD;

  aluCore #(.W(W)) uOpCore (
    .fn   (strb.fn),
    .a    (acc),
    .b    (operand),
    .cin  (carryFlag),
    .res  (opRes),
    .cout (opCout)
  );

  aluCore #(.W(W)) uStepCore (
    .fn   (stepFn),
    .a    (acc),
    .b    (ONE),
    .cin  (1'b0),
    .res  (stepRes),
    .cout (stepCout)
  );

  assign busOut = groupAlu ? opRes : acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      zeroFlag  <= 1'b0;
      carryFlag <= 1'b0;
      signFlag  <= 1'b0;
    end else if (strb.doLoad) begin
      acc <= operand;
    end else if (strb.doAlu) begin
      acc       <= opRes;
      carryFlag <= opCout;
      zeroFlag  <= (opRes == '0);
      signFlag  <= opRes[W-1];
    end else if (strb.doInc || strb.doDec) begin
      acc       <= stepRes;
      carryFlag <= stepCout;
      zeroFlag  <= (stepRes == '0);
      signFlag  <= stepRes[W-1];
    end
  end

  AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strb.doLoad |=> $stable({zeroFlag, carryFlag, signFlag})); // R2

  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doAlu && strb.fn[2]) |=> !carryFlag); // R5

  AST_ZERO_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doAlu || strb.doInc || strb.doDec) |=>
      (zeroFlag == (acc == '0)) && (signFlag == acc[W-1])); // R6

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.doInc |=> (acc == $past(acc) + ONE)); // R7

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.doDec |=> (acc == $past(acc) - ONE)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.doLoad || strb.doAlu || strb.doInc || strb.doDec) |=>
      $stable({acc, zeroFlag, carryFlag, signFlag})); // R11
endmodule

// File: rtl/opAluAcc.sv
module opAluAcc
  import aluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic              accLoad,
  input  logic              aluLoad,
  input  logic              incStrobe,
  input  logic              decStrobe,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] busOut,
  output logic              zeroFlag,
  output logic              carryFlag,
  output logic              signFlag
);
  ctrlStrobes_t strb;
  logic         groupAlu;

  aluCtrl #(.OPW(OP_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .opcode    (opcode),
    .accLoad   (accLoad),
    .aluLoad   (aluLoad),
    .incStrobe (incStrobe),
    .decStrobe (decStrobe),
    .strb      (strb),
    .groupAlu  (groupAlu)
  );

  accDatapath #(.W(DATA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .groupAlu  (groupAlu),
    .operand   (operand),
    .acc       (accOut),
    .busOut    (busOut),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag),
    .signFlag  (signFlag)
  );
endmodule

// File: tb/opAluAcc_test.sv
`timescale 1ns/1ps
module opAluAcc_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic       accLoad = 1'b0;
  logic       aluLoad = 1'b0;
  logic       incStrobe = 1'b0;
  logic       decStrobe = 1'b0;
  logic [7:0] accOut;
  logic [7:0] busOut;
  logic       zeroFlag;
  logic       carryFlag;
  logic       signFlag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int mAcc = 0;
  int mZ = 0;
  int mC = 0;
  int mS = 0;

  always #2.5 clk = ~clk;

  opAluAcc uut (
    .clk(clk), .rstN(rstN), .opcode(opcode), .operand(operand),
    .accLoad(accLoad), .aluLoad(aluLoad), .incStrobe(incStrobe),
    .decStrobe(decStrobe), .accOut(accOut), .busOut(busOut),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag), .signFlag(signFlag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural result of one opcode on (a, b, cin)
  task automatic refOp(input int op, input int a, input int b, input int cin,
                       output int r, output int co);
    int sel;
    int t;
    sel = (op >> 3) & 7;
    case (sel)
      0: t = a + b;
      1: t = a + b + cin;
      2: t = a - b;
      3: t = a - b - cin;
      4: t = (~a) & 255;
      5: t = a & b;
      6: t = a | b;
      default: t = a ^ b;
    endcase
    if (sel < 2) co = (t > 255) ? 1 : 0;
    else if (sel < 4) co = (t < 0) ? 1 : 0;
    else co = 0;
    r = t & 255;
  endtask

  task automatic compareState(input string tag);
    chk(tag, "acc", int'(accOut), mAcc);
    chk(tag, "zero", int'(zeroFlag), mZ);
    chk(tag, "carry", int'(carryFlag), mC);
    chk(tag, "sign", int'(signFlag), mS);
  endtask

  task automatic doStep(input string tag, input int op, input int val,
                        input bit ld, input bit alu, input bit inc, input bit dec);
    int r;
    int co;
    bit grp;
    @(negedge clk);
    opcode = 8'(op); operand = 8'(val);
    accLoad = ld; aluLoad = alu; incStrobe = inc; decStrobe = dec;
    grp = (((op >> 6) & 3) == 0);
    refOp(op, mAcc, val, mC, r, co);
    #1;
    chk("R10", "busOut", int'(busOut), grp ? r : mAcc);
    if (ld) mAcc = val;
    else if (alu) begin
      if (grp) begin mAcc = r; mC = co; mZ = (r == 0); mS = (r >> 7) & 1; end
    end else if (inc) begin
      mC = (mAcc == 255); mAcc = (mAcc + 1) & 255; mZ = (mAcc == 0); mS = (mAcc >> 7) & 1;
    end else if (dec) begin
      mC = (mAcc == 0); mAcc = (mAcc - 1) & 255; mZ = (mAcc == 0); mS = (mAcc >> 7) & 1;
    end
    @(negedge clk);
    accLoad = 0; aluLoad = 0; incStrobe = 0; decStrobe = 0;
    compareState(tag);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareState("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareState("R1");

    doStep("R2", 8'h00, 8'h3C, 1, 0, 0, 0);
    doStep("R4", 8'h00, 8'hC4, 0, 1, 0, 0);   // add -> 00h, carry, zero (R6)
    doStep("R4", 8'h08, 8'h05, 0, 1, 0, 0);   // add with carry
    doStep("R4", 8'h10, 8'h10, 0, 1, 0, 0);   // subtract with borrow out
    doStep("R4", 8'h18, 8'h01, 0, 1, 0, 0);   // subtract with borrow in
    doStep("R4", 8'h00, 8'h20, 0, 1, 0, 0);   // add sets carry
    doStep("R5", 8'h20, 8'h00, 0, 1, 0, 0);   // NOT clears carry
    doStep("R5", 8'h28, 8'h0F, 0, 1, 0, 0);   // AND
    doStep("R5", 8'h30, 8'h50, 0, 1, 0, 0);   // OR
    doStep("R6", 8'h38, 8'h5B, 0, 1, 0, 0);   // XOR to zero
    doStep("R2", 8'h00, 8'h80, 1, 0, 0, 0);   // load keeps zero flag
    doStep("R3", 8'h40, 8'hFF, 0, 1, 1, 0);
    doStep("R3", 8'h88, 8'h01, 0, 1, 0, 1);
    doStep("R3", 8'hC0, 8'h7F, 0, 1, 1, 1);
    doStep("R2", 8'h40, 8'hFF, 1, 0, 0, 0);
    doStep("R7", 8'h40, 8'h00, 0, 0, 1, 0);   // FFh wraps
    doStep("R7", 8'h40, 8'h00, 0, 0, 1, 0);
    doStep("R2", 8'h40, 8'h00, 1, 0, 0, 0);
    doStep("R8", 8'h40, 8'h00, 0, 0, 0, 1);   // 00h wraps
    doStep("R8", 8'h40, 8'h00, 0, 0, 0, 1);
    doStep("R9", 8'h00, 8'h42, 1, 1, 1, 1);
    doStep("R9", 8'h00, 8'h01, 0, 1, 1, 0);
    doStep("R9", 8'h00, 8'h00, 0, 0, 1, 1);
    doStep("R11", 8'h08, 8'h99, 0, 0, 0, 0);
    doStep("R11", 8'hFF, 8'h12, 0, 0, 0, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule